// File: doc/BRIEF.md
# Row Conversion and Readout Sequencer

This block steps a column-parallel image sensor through a frame one row at a time. For each row it puts a row address on the bus and pulses an active-low start strobe. It then waits for the sensor's active-low completion pulse. Next it pulses an active-low load strobe, which moves the digitized row into the sensor's output register. Finally it holds an active-low read enable for one pixel word per cycle, with a valid flag on each word that carries real row data.

Two scheduling modes are available.
- **Pipelined mode:** the next row's conversion starts two cycles after the current readout begins, so conversion and readout overlap. Each frame therefore has one extra leading readout that carries no row data.
- **Burst mode:** a conversion starts only when the output register is empty and both the load strobe and the read enable are inactive.

The row window and the blanking count are sampled when a frame starts. Blanking is the number of idle cycles appended after each readout. The block pulses a row tick as each row's conversion completes, and an end-of-frame pulse after the last readout. A completion pulse that does not arrive within a parameterised limit aborts the frame and raises an error pulse.

Top module: `row_readout_seq`

## Requirements
- R1: Out of reset the start, load and read-enable strobes are high (inactive), and pixel valid, row tick, end of frame, error and busy are low.
- R2: For a window with first row F and last row L (L >= F), one start strobe of exactly one cycle is issued per row, with addresses F, F+1, ..., L in that order. A window with L < F converts only row F.
- R3: The row address stays unchanged from the start strobe until the completion pulse is seen.
- R4: A converted row is moved by a one-cycle low load strobe. The read enable goes low in the next cycle and stays low for exactly ROW_WORDS cycles.
- R5: In pipelined mode every start strobe falls in the third cycle of a readout, that is, two cycles after the read enable went low, and never earlier.
- R6: In pipelined mode a frame of N rows makes N+1 readouts. The first readout has pixel valid low throughout, and the rest deliver N*ROW_WORDS valid words.
- R7: In burst mode a start strobe occurs only while the load strobe and the read enable are both high. A frame of N rows makes N readouts, every word of which is valid.
- R8: With blanking B, the read enable stays high for exactly B+2 cycles between readouts in pipelined mode, provided the conversion finishes in time. In burst mode, where the completion pulse comes D cycles after the strobe, the gap is B+D+4 cycles.
- R9: A completion pulse seen up to TIMEOUT cycles after the start strobe is accepted. If it has not arrived by then, error pulses for one cycle, busy drops, the read enable returns high and no end of frame is given.
- R10: Row tick pulses once per completed conversion. End of frame pulses once after the final readout, in the same cycle that busy drops.
- R11: While a frame is running, the start input and changes to the window, mode and blanking inputs have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request, sampled when idle |
| pipe_mode_i | input | 1 | 1 = pipelined scheduling, 0 = burst |
| win_first_i | input | ROW_AW | First row of the window |
| win_last_i | input | ROW_AW | Last row of the window |
| blank_i | input | BLANK_W | Idle cycles after each readout |
| row_done_n_i | input | 1 | Conversion complete from sensor, active low |
| row_addr_o | output | ROW_AW | Row address to sensor |
| row_strt_n_o | output | 1 | Row conversion start, active low |
| ld_shft_n_o | output | 1 | Load output register, active low |
| rd_en_n_o | output | 1 | Output register read enable, active low |
| pix_valid_o | output | 1 | Current pixel word carries row data |
| row_tick_o | output | 1 | Pulse per completed row conversion |
| eof_o | output | 1 | Pulse after the last readout of a frame |
| err_o | output | 1 | Pulse on completion timeout |
| busy_o | output | 1 | Frame in progress |

## Verification
The completion pulse and the expiry of the timeout window can fall in the same cycle. In that case the completion must win. The bench provokes this with a sensor model whose completion delay equals TIMEOUT, and judges the frame by a full row count, an end of frame and no error pulse. A delay of TIMEOUT+1 must give an error pulse, no end of frame and an idle block. In pipelined mode, a conversion can complete in the cycle the readout finishes its blanking. The bench tunes the delay so that these coincide and checks that the gap stays at exactly B+2.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;
  typedef enum logic [1:0] {CV_IDLE, CV_STRB, CV_WAIT} conv_st_e;
  typedef enum logic [1:0] {RO_IDLE, RO_LOAD, RO_READ, RO_BLANK} rdo_st_e;
  typedef enum logic {SQ_IDLE, SQ_RUN} seq_st_e;
endpackage

// File: rtl/row_win_cnt.sv
module row_win_cnt #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          more_o
);
  localparam int unsigned LW = AW + 1;

  logic [AW-1:0] next_q, addr_q;
  logic [LW-1:0] left_q, span;

  // reversed window degenerates to a single row
  assign span = (last_i >= first_i) ? (LW'(last_i) - LW'(first_i) + LW'(1)) : LW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      addr_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      next_q <= first_i;
      left_q <= span;
    end else if (step_i && left_q != '0) begin
      addr_q <= next_q;
      next_q <= next_q + AW'(1);
      left_q <= left_q - LW'(1);
    end
  end

  assign addr_o = addr_q;
  assign more_o = (left_q != '0);
endmodule

// File: rtl/row_conv_hs.sv
module row_conv_hs import row_seq_pkg::*; #(
  parameter int unsigned TIMEOUT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic row_done_n_i,
  output logic strt_n_o,
  output logic busy_o,
  output logic done_o,
  output logic tmo_o
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);

  conv_st_e      st_q, st_d;
  logic [TW-1:0] cnt_q;

  always_comb begin
    st_d   = st_q;
    done_o = 1'b0;
    tmo_o  = 1'b0;
    unique case (st_q)
      CV_IDLE: if (go_i) st_d = CV_STRB;
      CV_STRB: st_d = CV_WAIT;
      CV_WAIT: begin
        // a response in the last allowed cycle still counts
        if (!row_done_n_i) begin
          done_o = 1'b1;
          st_d   = CV_IDLE;
        end else if (cnt_q == TW'(TIMEOUT - 1)) begin
          tmo_o = 1'b1;
          st_d  = CV_IDLE;
        end
      end
      default: st_d = CV_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CV_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == CV_WAIT) ? cnt_q + TW'(1) : '0;
    end
  end

  assign strt_n_o = (st_q != CV_STRB);
  assign busy_o   = (st_q != CV_IDLE);
endmodule

// File: rtl/row_readout.sv
module row_readout import row_seq_pkg::*; #(
  parameter int unsigned WORDS   = 1280,
  parameter int unsigned BLANK_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic               valid_row_i,
  input  logic               abort_i,
  input  logic [BLANK_W-1:0] blank_i,
  output logic               ld_n_o,
  output logic               rd_en_n_o,
  output logic               pix_valid_o,
  output logic               launch_o,
  output logic               busy_o
);
  localparam int unsigned WW = (WORDS > 2) ? $clog2(WORDS) : 2;

  rdo_st_e            st_q, st_d;
  logic [WW-1:0]      wcnt_q;
  logic [BLANK_W-1:0] bcnt_q, blank_q;
  logic               vrow_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RO_IDLE:  if (go_i) st_d = RO_LOAD;
      RO_LOAD:  st_d = RO_READ;
      RO_READ:  if (wcnt_q == WW'(WORDS - 1)) st_d = (blank_q == '0) ? RO_IDLE : RO_BLANK;
      RO_BLANK: if (bcnt_q == blank_q - BLANK_W'(1)) st_d = RO_IDLE;
      default:  st_d = RO_IDLE;
    endcase
    if (abort_i) st_d = RO_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RO_IDLE;
      wcnt_q  <= '0;
      bcnt_q  <= '0;
      blank_q <= '0;
      vrow_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= (st_q == RO_READ) ? wcnt_q + WW'(1) : '0;
      bcnt_q <= (st_q == RO_BLANK) ? bcnt_q + BLANK_W'(1) : '0;
      if (st_q == RO_IDLE && go_i) begin
        blank_q <= blank_i;
        vrow_q  <= valid_row_i;
      end
    end
  end

  assign ld_n_o      = (st_q != RO_LOAD);
  assign rd_en_n_o   = (st_q != RO_READ);
  assign pix_valid_o = (st_q == RO_READ) && vrow_q;
  // two cycles into the read: earliest legal conversion restart
  assign launch_o    = (st_q == RO_READ) && (wcnt_q == WW'(1));
  assign busy_o      = (st_q != RO_IDLE);
endmodule

// File: rtl/row_readout_seq.sv
module row_readout_seq import row_seq_pkg::*; #(
  parameter int unsigned ROW_AW    = 10,
  parameter int unsigned ROW_WORDS = 1280,
  parameter int unsigned BLANK_W   = 8,
  parameter int unsigned TIMEOUT   = 4096
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               pipe_mode_i,
  input  logic [ROW_AW-1:0]  win_first_i,
  input  logic [ROW_AW-1:0]  win_last_i,
  input  logic [BLANK_W-1:0] blank_i,
  input  logic               row_done_n_i,
  output logic [ROW_AW-1:0]  row_addr_o,
  output logic               row_strt_n_o,
  output logic               ld_shft_n_o,
  output logic               rd_en_n_o,
  output logic               pix_valid_o,
  output logic               row_tick_o,
  output logic               eof_o,
  output logic               err_o,
  output logic               busy_o
);
  seq_st_e            st_q;
  logic               pipe_q, adc_full_q, pend_q, eof_q, err_q, tick_q;
  logic [BLANK_W-1:0] blank_q;
  logic               conv_go, conv_busy, conv_done, conv_tmo;
  logic               rd_go, rd_busy, rd_launch;
  logic               win_load, win_more, frame_end, running;

  assign running  = (st_q == SQ_RUN);
  assign win_load = !running && start_i;

  always_comb begin
    conv_go   = 1'b0;
    rd_go     = 1'b0;
    frame_end = 1'b0;
    if (running && !conv_tmo) begin
      if (pipe_q) begin
        if (rd_launch && pend_q) conv_go = 1'b1;
        if (!rd_busy && !conv_busy && !pend_q) begin
          // leading slot reads an empty register while row 0 converts
          if (adc_full_q || win_more) rd_go = 1'b1;
          else frame_end = 1'b1;
        end
      end else if (!rd_busy && !conv_busy) begin
        if (adc_full_q)    rd_go     = 1'b1;
        else if (win_more) conv_go   = 1'b1;
        else               frame_end = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      pipe_q     <= 1'b0;
      blank_q    <= '0;
      adc_full_q <= 1'b0;
      pend_q     <= 1'b0;
      eof_q      <= 1'b0;
      err_q      <= 1'b0;
      tick_q     <= 1'b0;
    end else begin
      eof_q  <= frame_end;
      err_q  <= conv_tmo;
      tick_q <= conv_done;
      if (win_load) begin
        st_q       <= SQ_RUN;
        pipe_q     <= pipe_mode_i;
        blank_q    <= blank_i;
        adc_full_q <= 1'b0;
        pend_q     <= 1'b0;
      end else if (running) begin
        if (conv_tmo || frame_end) st_q <= SQ_IDLE;
        if (conv_done)  adc_full_q <= 1'b1;
        else if (rd_go) adc_full_q <= 1'b0;
        if (rd_go)        pend_q <= pipe_q && win_more;
        else if (conv_go) pend_q <= 1'b0;
      end
    end
  end

  row_win_cnt #(.AW(ROW_AW)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (win_load),
    .first_i (win_first_i),
    .last_i  (win_last_i),
    .step_i  (conv_go),
    .addr_o  (row_addr_o),
    .more_o  (win_more)
  );

  row_conv_hs #(.TIMEOUT(TIMEOUT)) u_conv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (conv_go),
    .row_done_n_i (row_done_n_i),
    .strt_n_o     (row_strt_n_o),
    .busy_o       (conv_busy),
    .done_o       (conv_done),
    .tmo_o        (conv_tmo)
  );

  row_readout #(.WORDS(ROW_WORDS), .BLANK_W(BLANK_W)) u_rdo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (rd_go),
    .valid_row_i (adc_full_q),
    .abort_i     (conv_tmo),
    .blank_i     (blank_q),
    .ld_n_o      (ld_shft_n_o),
    .rd_en_n_o   (rd_en_n_o),
    .pix_valid_o (pix_valid_o),
    .launch_o    (rd_launch),
    .busy_o      (rd_busy)
  );

  assign row_tick_o = tick_q;
  assign eof_o      = eof_q;
  assign err_o      = err_q;
  assign busy_o     = running;
endmodule

// File: rtl/row_readout_seq_chk.sv
module row_readout_seq_chk #(
  parameter int unsigned ROW_AW  = 10,
  parameter int unsigned TIMEOUT = 4096
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              row_done_n_i,
  input logic [ROW_AW-1:0] row_addr_o,
  input logic              row_strt_n_o,
  input logic              ld_shft_n_o,
  input logic              rd_en_n_o,
  input logic              pix_valid_o,
  input logic              eof_o,
  input logic              err_o,
  input logic              busy_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 4);

  logic          in_conv_q;
  logic [CW-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_conv_q <= 1'b0;
      wait_q    <= '0;
    end else if (!row_strt_n_o) begin
      in_conv_q <= 1'b1;
      wait_q    <= CW'(1);
    end else if (in_conv_q && (!row_done_n_i || err_o)) begin
      in_conv_q <= 1'b0;
      wait_q    <= '0;
    end else if (in_conv_q && wait_q != '1) begin
      wait_q <= wait_q + CW'(1);
    end
  end

  assert_strobe_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_strt_n_o |=> row_strt_n_o);

  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_conv_q |-> $stable(row_addr_o));

  assert_load_then_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_shft_n_o |=> !rd_en_n_o);

  assert_strobe_not_on_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_strt_n_o |-> ld_shft_n_o);

  assert_restart_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_strt_n_o && !rd_en_n_o) |-> (!$past(rd_en_n_o) && !$past(rd_en_n_o, 2)));

  assert_valid_in_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> !rd_en_n_o);

  assert_wait_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_conv_q |-> (wait_q <= CW'(TIMEOUT + 1)));

  assert_eof_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> (!busy_o && rd_en_n_o));

  assert_eof_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);
endmodule

bind row_readout_seq row_readout_seq_chk #(.ROW_AW(ROW_AW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .row_done_n_i (row_done_n_i),
  .row_addr_o   (row_addr_o),
  .row_strt_n_o (row_strt_n_o),
  .ld_shft_n_o  (ld_shft_n_o),
  .rd_en_n_o    (rd_en_n_o),
  .pix_valid_o  (pix_valid_o),
  .eof_o        (eof_o),
  .err_o        (err_o),
  .busy_o       (busy_o)
);

// File: tb/row_readout_seq_tb_top.sv
`timescale 1ns/1ps
module row_readout_seq_tb_top;
  localparam int AW = 10;
  localparam int W  = 8;
  localparam int BW = 4;
  localparam int TO = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          pipe_mode_i = 1'b0;
  logic [AW-1:0] win_first_i = '0;
  logic [AW-1:0] win_last_i = '0;
  logic [BW-1:0] blank_i = '0;
  logic          row_done_n_i = 1'b1;
  logic [AW-1:0] row_addr_o;
  logic          row_strt_n_o, ld_shft_n_o, rd_en_n_o, pix_valid_o;
  logic          row_tick_o, eof_o, err_o, busy_o;

  always #2 clk_i = ~clk_i;

  row_readout_seq #(.ROW_AW(AW), .ROW_WORDS(W), .BLANK_W(BW), .TIMEOUT(TO)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pipe_mode_i(pipe_mode_i),
    .win_first_i(win_first_i), .win_last_i(win_last_i), .blank_i(blank_i),
    .row_done_n_i(row_done_n_i), .row_addr_o(row_addr_o), .row_strt_n_o(row_strt_n_o),
    .ld_shft_n_o(ld_shft_n_o), .rd_en_n_o(rd_en_n_o), .pix_valid_o(pix_valid_o),
    .row_tick_o(row_tick_o), .eof_o(eof_o), .err_o(err_o), .busy_o(busy_o)
  );

  int checks = 0;
  int errors = 0;

  // monitor state
  int conv_addr [16];
  int n_conv, n_ld, n_valid, n_inval, n_stray, n_tick, n_eof, n_err, n_reads;
  int bad_strb, bad_gap, bad_len, rsp_bad;
  int lo_run = 0, hi_run = 0, gap_exp = -1;
  bit mode_exp = 1'b0;
  int rsp_delay = 5;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    n_conv = 0; n_ld = 0; n_valid = 0; n_inval = 0; n_stray = 0; n_tick = 0;
    n_eof = 0; n_err = 0; n_reads = 0; bad_strb = 0; bad_gap = 0; bad_len = 0; rsp_bad = 0;
    for (int i = 0; i < 16; i++) conv_addr[i] = -1;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!row_strt_n_o) begin
        if (n_conv < 16) conv_addr[n_conv] = int'(row_addr_o);
        n_conv++;
        if (mode_exp) begin
          if (rd_en_n_o || lo_run != 2) bad_strb++;
        end else if (!rd_en_n_o || !ld_shft_n_o) bad_strb++;
      end
      if (!ld_shft_n_o) n_ld++;
      if (!rd_en_n_o) begin
        if (pix_valid_o) n_valid++; else n_inval++;
        if (lo_run == 0) begin
          if (n_reads > 0 && gap_exp >= 0 && hi_run != gap_exp) bad_gap++;
          n_reads++;
        end
        lo_run++;
        hi_run = 0;
      end else begin
        if (pix_valid_o) n_stray++;
        if (lo_run > 0 && lo_run != W) bad_len++;
        lo_run = 0;
        hi_run++;
      end
      if (row_tick_o) n_tick++;
      if (eof_o) n_eof++;
      if (err_o) n_err++;
    end
  end

  // sensor model: completion pulse rsp_delay cycles after the strobe cycle
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && !row_strt_n_o) begin
        automatic logic [AW-1:0] a = row_addr_o;
        repeat (rsp_delay) @(negedge clk_i);
        if (row_addr_o != a) rsp_bad++;
        row_done_n_i = 1'b0;
        @(negedge clk_i);
        row_done_n_i = 1'b1;
      end
    end
  end

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 strobe", int'(row_strt_n_o), 1);
    chk("R1 load", int'(ld_shft_n_o), 1);
    chk("R1 read enable", int'(rd_en_n_o), 1);
    chk("R1 flags", int'({pix_valid_o, row_tick_o, eof_o, err_o, busy_o}), 0);
  endtask

  task automatic start_frame(input bit pipe, input int first, input int last,
                             input int blank, input int delay, input int gexp);
    clear_stats();
    mode_exp = pipe; rsp_delay = delay; gap_exp = gexp;
    pipe_mode_i = pipe; win_first_i = AW'(first); win_last_i = AW'(last); blank_i = BW'(blank);
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R11: disturb everything while the frame runs
    win_first_i = AW'(first + 3); win_last_i = AW'(first + 1);
    blank_i = BW'(blank + 1); pipe_mode_i = !pipe; start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    for (int i = 0; i < 4000 && n_eof == 0 && n_err == 0; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic run_frame(input bit pipe, input int first, input int last,
                           input int blank, input int delay, input bit gap_on);
    int n, mism, gexp;
    n = (last >= first) ? last - first + 1 : 1;
    gexp = !gap_on ? -1 : (pipe ? blank + 2 : blank + delay + 4);
    start_frame(pipe, first, last, blank, delay, gexp);
    mism = 0;
    for (int i = 0; i < n && i < 16; i++) if (conv_addr[i] != first + i) mism++;
    chk("R2 conversions", n_conv, n);
    chk("R2 address order", mism, 0);
    chk("R11 frame unaffected by busy-time inputs", mism + (n_conv - n), 0);
    chk("R3 address held to completion", rsp_bad, 0);
    chk("R4 readout length", bad_len, 0);
    chk("R4 stray valid", n_stray, 0);
    chk("R6 R7 valid words", n_valid, n * W);
    if (pipe) begin
      chk("R5 restart gap", bad_strb, 0);
      chk("R6 readouts", n_ld, n + 1);
      chk("R6 leading empty readout", n_inval, W);
    end else begin
      chk("R7 strobe outside readout", bad_strb, 0);
      chk("R7 readouts", n_ld, n);
      chk("R7 invalid words", n_inval, 0);
    end
    if (gap_on) chk("R8 blanking gap", bad_gap, 0);
    chk("R10 row ticks", n_tick, n);
    chk("R10 end of frame", n_eof, 1);
    chk("R10 busy released", int'(busy_o), 0);
    chk("R9 no error", n_err, 0);
  endtask

  task automatic t_timeout();
    start_frame(1'b0, 100, 102, 1, TO + 1, -1);
    chk("R9 error pulse", n_err, 1);
    chk("R9 no end of frame", n_eof, 0);
    chk("R9 busy dropped", int'(busy_o), 0);
    chk("R9 read enable high", int'(rd_en_n_o), 1);
    chk("R9 no load", n_ld, 0);
    chk("R9 one conversion", n_conv, 1);
    repeat (30) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL R10 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    run_frame(1'b1, 5, 8, 0, 5, 1'b1);        // pipelined, conversion ends as blanking ends
    run_frame(1'b1, 1020, 1023, 3, 2, 1'b1);  // pipelined, top of address range
    run_frame(1'b0, 0, 2, 2, 3, 1'b1);        // burst
    run_frame(1'b1, 7, 7, 1, 3, 1'b1);        // single row
    run_frame(1'b1, 9, 3, 0, 3, 1'b1);        // reversed window converts first row only
    run_frame(1'b0, 50, 51, 1, TO, 1'b1);     // completion on the last allowed cycle
    t_timeout();
    run_frame(1'b0, 200, 201, 0, 4, 1'b1);    // recovery after error
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule